// File: doc/BRIEF.md
# Equivalent-Time Successive-Approximation Digitizer

This block digitizes a repetitive analog waveform with an external 1-bit comparator and an external DAC. Each record holds NPOS sample positions. Every position owns one on-chip memory entry with its partial conversion code and a bit pointer. On each sync pulse the block walks through the positions in order, one per clock. For each position it drives the stored trial code to the DAC. After a fixed settle delay it takes the comparator decision and writes the updated entry back. The result is that each signal period resolves one more bit of every position.

A start pulse, or reset, clears every entry to mid-scale and latches the conversion mode. There are two modes. Binary search resolves one bit per period. Tracking moves each code one step per period toward the input. The comparator word carries LANES samples per clock. The block either uses only the earliest sample or takes a vote across all of them. Finished codes are read through a one-cycle read port that does not disturb an acquisition.

Top module: `et_sar_digitizer`

## Requirements
- R1: After reset, or in the cycle after a start pulse, the block clears all NPOS entries over NPOS cycles. Each entry is set to code 2^(RES-1) with its pointer at bit RES-1 and not finished. During the clear, dac_vld stays 0, rd_valid reads 0, done is 0, and sync edges are ignored.
- R2: A rising sync edge seen while the block is idle raises dac_vld in the next cycle. dac_vld then stays high for exactly NPOS consecutive cycles, presenting positions 0, 1, ..., NPOS-1 in order.
- R3: The comparator word present SETTLE cycles after the cycle in which a position's code is on dac_code decides that position. A decided 1 means the input is above the DAC level.
- R4: In binary mode each visit does three things. It keeps the trial bit if the decision is 1 and clears it otherwise. It then sets the next lower bit as the new trial. After RES visits the code equals 0 for an input level v=0, v-1 for 1<=v<=2^RES, and 2^RES-1 above that (comparator true when code < v).
- R5: An entry becomes finished on its RES-th visit. After RES-1 sweeps, rd_valid is 0 and done is 0.
- R6: In tracking mode each visit adds 1 to the code on a decision of 1 and subtracts 1 otherwise, saturating at 0 and 2^RES-1. Entries become finished after RES visits and keep tracking afterwards.
- R7: With decimation on, only cmp_word[0] (the earliest sample) counts. With it off, the decision is 1 when at least LANES/2 lanes are 1.
- R8: A sync edge that arrives while a sweep is issuing positions, or while its comparator results are still pending, is ignored.
- R9: done rises once every position is finished. It stays high until the next start. In binary mode further sweeps leave finished codes unchanged.
- R10: rd_code and rd_valid show the entry at rd_addr one cycle after rd_addr is applied. Reading during a sweep does not alter the results.
- R11: track_mode and decim are sampled only on a start pulse. Changing them afterwards has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts a clear |
| start | input | 1 | Clears all entries and latches the mode inputs |
| track_mode | input | 1 | 1 selects tracking, 0 selects binary search |
| decim | input | 1 | 1 uses only lane 0 of the comparator word |
| sync | input | 1 | Signal period marker; rising edge begins a sweep |
| cmp_word | input | LANES | Deserialized comparator samples, bit 0 earliest |
| rd_addr | input | clog2(NPOS) | Position to read |
| dac_code | output | RES | Trial code for the DAC |
| dac_vld | output | 1 | dac_code belongs to a position in the current sweep |
| rd_code | output | RES | Code of the addressed entry |
| rd_valid | output | 1 | Addressed entry has resolved its LSB |
| done | output | 1 | All positions resolved |

## Verification
The hardest situation to reach is a sync edge that lands after the last position has been issued but while comparator results are still in the settle pipeline. Accepting it there would silently overlap two sweeps. The bench raises sync in the middle of every other sweep and again on the first cycle after dac_vld falls. It then checks that the sweep length stays at NPOS and that no new sweep starts. The comparator model is a second hard point. It keeps its own SETTLE-deep history of the DAC outputs. In vote mode it sends random lane patterns whose number of ones lies exactly on either side of the threshold, so a shifted delay or a wrong lane choice corrupts the final codes.

// File: rtl/et_sar_digitizer.sv
module et_sar_digitizer #(
  parameter int RES    = 8,
  parameter int NPOS   = 1024,
  parameter int SETTLE = 3,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      track_mode,
  input  logic                      decim,
  input  logic                      sync,
  input  logic [LANES-1:0]          cmp_word,
  input  logic [$clog2(NPOS)-1:0]   rd_addr,
  output logic [RES-1:0]            dac_code,
  output logic                      dac_vld,
  output logic [RES-1:0]            rd_code,
  output logic                      rd_valid,
  output logic                      done
);

  localparam int AW = $clog2(NPOS);
  localparam int PW = (RES > 1) ? $clog2(RES) : 1;
  localparam int CW = $clog2(NPOS + 1);
  localparam int LW = $clog2(LANES + 1);
  localparam logic [RES-1:0] MID  = RES'(1) << (RES - 1);
  localparam logic [RES-1:0] TOP  = '1;
  localparam logic [PW-1:0]  PTR0 = PW'(RES - 1);
  localparam logic [LW-1:0]  HALF = LW'(LANES / 2);
  localparam logic [AW-1:0]  LAST = AW'(NPOS - 1);
  localparam logic [CW-1:0]  ALL  = CW'(NPOS);

  typedef struct packed {
    logic [RES-1:0] code;
    logic [PW-1:0]  ptr;
    logic           fin;
  } slot_t;

  localparam slot_t FRESH = '{code: MID, ptr: PTR0, fin: 1'b0};

  slot_t          mem [NPOS];
  logic           clearing;
  logic [AW-1:0]  clr_idx;
  logic           trk, dcm, sync_q, issuing;
  logic [AW-1:0]  iss_pos;
  logic [SETTLE:0] st_vld;
  logic [AW-1:0]  st_pos [SETTLE+1];
  logic [CW-1:0]  done_cnt;

  logic           sweep_busy, go, issue_now, above, wb_en, newfin;
  logic [AW-1:0]  sel, wb_pos;
  logic [LW-1:0]  ones;
  slot_t          cur, nxt;

  assign sweep_busy = issuing | (|st_vld);
  assign go         = sync & ~sync_q & ~clearing & ~sweep_busy & ~start;
  assign issue_now  = go | issuing;
  assign sel        = go ? '0 : iss_pos;
  assign wb_en      = st_vld[SETTLE];
  assign wb_pos     = st_pos[SETTLE];
  assign cur        = mem[wb_pos];
  assign dac_vld    = st_vld[0];
  assign done       = (done_cnt == ALL);

  always_comb begin
    ones = '0;
    for (int i = 0; i < LANES; i++) ones = ones + LW'(cmp_word[i]);
  end

  assign above = dcm ? cmp_word[0] : (ones >= HALF);

  always_comb begin
    nxt = cur;
    if (trk) begin
      if (above) nxt.code = (cur.code == TOP) ? TOP : cur.code + 1'b1;
      else       nxt.code = (cur.code == '0)  ? '0  : cur.code - 1'b1;
      if (!cur.fin) begin
        if (cur.ptr == '0) nxt.fin = 1'b1;
        else               nxt.ptr = cur.ptr - 1'b1;
      end
    end else if (!cur.fin) begin
      if (!above) nxt.code[cur.ptr] = 1'b0;
      if (cur.ptr == '0) nxt.fin = 1'b1;
      else begin
        nxt.ptr = cur.ptr - 1'b1;
        nxt.code[cur.ptr - 1'b1] = 1'b1;
      end
    end
  end

  assign newfin = wb_en & nxt.fin & ~cur.fin;

  always_ff @(posedge clk) begin
    if (clearing)   mem[clr_idx] <= FRESH;
    else if (wb_en) mem[wb_pos]  <= nxt;
  end

  always_ff @(posedge clk) begin
    st_pos[0] <= sel;
    for (int i = 1; i <= SETTLE; i++) st_pos[i] <= st_pos[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clearing <= 1'b1;
      clr_idx  <= '0;
      trk      <= 1'b0;
      dcm      <= 1'b0;
      sync_q   <= 1'b0;
      issuing  <= 1'b0;
      iss_pos  <= '0;
      st_vld   <= '0;
      done_cnt <= '0;
      dac_code <= '0;
      rd_code  <= '0;
      rd_valid <= 1'b0;
    end else begin
      sync_q   <= sync;
      rd_code  <= mem[rd_addr].code;
      rd_valid <= mem[rd_addr].fin & ~clearing & ~start;
      if (start) begin
        clearing <= 1'b1;
        clr_idx  <= '0;
        trk      <= track_mode;
        dcm      <= decim;
        issuing  <= 1'b0;
        st_vld   <= '0;
        done_cnt <= '0;
      end else begin
        if (clearing) begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == LAST) clearing <= 1'b0;
        end
        if (issue_now) begin
          dac_code <= mem[sel].code;
          iss_pos  <= sel + 1'b1;
        end
        issuing   <= issue_now & (sel != LAST);
        st_vld[0] <= issue_now;
        for (int i = 1; i <= SETTLE; i++) st_vld[i] <= st_vld[i-1];
        if (newfin) done_cnt <= done_cnt + 1'b1;
      end
    end
  end

  // R1
  idle_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> !dac_vld);

  // R2
  walk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_vld && $past(dac_vld)) |-> (st_pos[0] == AW'($past(st_pos[0]) + 1'b1)));

  // R8
  sync_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy |=> !(dac_vld && st_pos[0] == '0));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R9
  done_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_cnt <= ALL);

endmodule

// File: tb/tb_et_sar_digitizer.sv
module tb_et_sar_digitizer;
  localparam int RES = 8;
  localparam int NP  = 64;
  localparam int ST  = 3;
  localparam int LN  = 4;
  localparam int AW  = $clog2(NP);
  localparam int TOPV = (1 << RES) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, track_mode = 1'b0, decim = 1'b0, sync = 1'b0;
  logic [LN-1:0]  cmp_word = '0;
  logic [AW-1:0]  rd_addr = '0;
  logic [RES-1:0] dac_code, rd_code;
  logic           dac_vld, rd_valid, done;

  always #5 clk = ~clk;

  et_sar_digitizer #(.RES(RES), .NPOS(NP), .SETTLE(ST), .LANES(LN)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .track_mode(track_mode), .decim(decim),
    .sync(sync), .cmp_word(cmp_word), .rd_addr(rd_addr), .dac_code(dac_code),
    .dac_vld(dac_vld), .rd_code(rd_code), .rd_valid(rd_valid), .done(done));

  int refv [NP];
  int checks = 0, errors = 0;
  bit bdec = 1'b0;
  int bpos = 0;
  logic hv [ST+1];
  int   hc [ST+1];
  int   hp [ST+1];

  function automatic logic [LN-1:0] lanes(bit t, bit dec);
    logic [LN-1:0] r;
    int k;
    if (dec) begin
      r = LN'($urandom);
      r[0] = t;
    end else begin
      k = t ? 2 + int'($urandom % 3) : int'($urandom % 2);
      do r = LN'($urandom); while ($countones(r) != k);
    end
    return r;
  endfunction

  function automatic int exp_bin(int v);
    if (v == 0) return 0;
    return (v - 1 > TOPV) ? TOPV : v - 1;
  endfunction

  function automatic int exp_trk(int v, int n);
    int c = 1 << (RES - 1);
    for (int i = 0; i < n; i++) begin
      if (c < v) c = (c == TOPV) ? TOPV : c + 1;
      else       c = (c == 0) ? 0 : c - 1;
    end
    return c;
  endfunction

  initial for (int i = 0; i <= ST; i++) begin hv[i] = 1'b0; hc[i] = 0; hp[i] = 0; end

  always @(negedge clk) begin
    for (int i = ST; i > 0; i--) begin hv[i] = hv[i-1]; hc[i] = hc[i-1]; hp[i] = hp[i-1]; end
    hv[0] = dac_vld;
    hc[0] = int'(dac_code);
    hp[0] = bpos;
    if (dac_vld) bpos = (bpos + 1) % NP;
    cmp_word <= lanes(hv[ST] ? (hc[ST] < refv[hp[ST]]) : bit'($urandom), bdec);
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd(int a, output int code, output bit v);
    rd_addr = AW'(a);
    tick();
    code = int'(rd_code);
    v = rd_valid;
  endtask

  task automatic do_start(bit trk, bit dec);
    start = 1'b1; track_mode = trk; decim = dec; bdec = dec; bpos = 0;
    tick();
    start = 1'b0;
    track_mode = ~trk;  // R11: live inputs must not matter any more
    decim = ~dec;
    sync = 1'b1;
    tick();
    sync = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(int'(dac_vld), 0, "R1 sync ignored while clearing");
      tick();
    end
    chk(int'(done), 0, "R1 done low after start");
    repeat (NP + 4) tick();
  endtask

  task automatic sweep(int first_exp, bit extra);
    int cnt = 0;
    sync = 1'b1;
    tick();
    sync = 1'b0;
    chk(int'(dac_vld), 1, "R2 sweep begins one cycle after sync edge");
    if (first_exp >= 0) chk(int'(dac_code), first_exp, "R2 position 0 code first");
    while (dac_vld && cnt < 2 * NP) begin
      cnt++;
      rd_addr = AW'($urandom);
      if (extra && cnt == NP / 2) sync = 1'b1;
      if (extra && cnt == NP / 2 + 2) sync = 1'b0;
      tick();
    end
    chk(cnt, NP, "R2 R8 exactly one visit per position");
    if (extra) begin
      sync = 1'b1;
      tick();
      sync = 1'b0;
    end
    for (int i = 0; i < ST + 3; i++) begin
      chk(int'(dac_vld), 0, "R8 sync during drain ignored");
      tick();
    end
  endtask

  initial begin
    int c;
    bit v;
    void'($urandom(32'd2024));
    for (int p = 0; p < NP; p++) refv[p] = 0;
    repeat (3) tick();
    chk(int'(dac_vld), 0, "R1 dac_vld low in reset");
    rst_n = 1'b1;
    tick();
    chk(int'(done), 0, "R1 done low after reset");
    repeat (NP + 4) tick();
    rd(5, c, v);
    chk(int'(v), 0, "R1 entry not valid after reset clear");

    // binary search, lane 0 only, noisy other lanes
    for (int p = 0; p < NP; p++) refv[p] = int'($urandom % 300);
    refv[0] = 0; refv[1] = 1; refv[2] = 255; refv[3] = 256;
    refv[4] = 300; refv[5] = 128; refv[6] = 129;
    do_start(1'b0, 1'b1);
    rd(3, c, v);
    chk(int'(v), 0, "R1 entry not valid after start clear");
    for (int s = 1; s <= RES - 1; s++)
      sweep((s == 1) ? 128 : ((s == 2) ? 64 : -1), s[0]);
    chk(int'(done), 0, "R5 done low after RES-1 sweeps");
    rd(3, c, v);
    chk(int'(v), 0, "R5 entry not valid after RES-1 sweeps");
    sweep(-1, 1'b1);
    chk(int'(done), 1, "R9 done after RES sweeps");
    for (int p = 0; p < NP; p++) begin
      rd(p, c, v);
      chk(int'(v), 1, "R5 R10 entry valid after RES sweeps");
      chk(c, exp_bin(refv[p]), "R3 R4 R7 R10 R11 binary code lane 0");
    end
    sweep(-1, 1'b0);
    chk(int'(done), 1, "R9 done holds");
    for (int p = 0; p < NP; p += 7) begin
      rd(p, c, v);
      chk(c, exp_bin(refv[p]), "R9 finished code frozen");
    end

    // binary search, lane vote
    for (int p = 0; p < NP; p++) refv[p] = int'($urandom % 280);
    refv[0] = 256; refv[1] = 0;
    do_start(1'b0, 1'b0);
    chk(int'(done), 0, "R9 done cleared by start");
    for (int s = 1; s <= RES; s++) sweep(-1, s[0]);
    chk(int'(done), 1, "R9 done after RES vote sweeps");
    for (int p = 0; p < NP; p++) begin
      rd(p, c, v);
      chk(c, exp_bin(refv[p]), "R7 R11 binary code lane vote");
    end

    // tracking
    for (int p = 0; p < NP; p++) refv[p] = 116 + int'($urandom % 25);
    refv[0] = 0; refv[1] = 400; refv[2] = 128;
    do_start(1'b1, 1'b1);
    for (int s = 1; s <= RES; s++) sweep(-1, s[0]);
    chk(int'(done), 1, "R6 done after RES tracking sweeps");
    for (int p = 0; p < NP; p++) begin
      rd(p, c, v);
      chk(int'(v), 1, "R6 tracking entry valid");
      chk(c, exp_trk(refv[p], RES), "R6 tracking code");
    end
    for (int s = 0; s < 3; s++) sweep(-1, 1'b0);
    for (int p = 0; p < NP; p++) begin
      rd(p, c, v);
      chk(c, exp_trk(refv[p], RES + 3), "R6 tracking continues after done");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule